// File: doc/BRIEF.md
# Variable-Page-Size Set-Associative Translation Buffer

This block caches virtual-to-physical mappings for a memory pipeline. The mappings are held in a parameterised array of sets and ways. Each entry records its own page size as a log2 value, so one array can hold 4 KiB pages next to 2 MiB or 4 MiB pages. An entry matches when the lookup address falls inside the address range the entry covers. It does not need an exact tag match.

The buffer takes four kinds of operation:
- a lookup, which may optionally refresh the recency of the entry it hits;
- a fill, which places a new entry in a free way or replaces the least-recently-used one;
- a flush of the whole array;
- the removal of the single page that covers a given address.

A lookup answers one cycle later with the following:
- hit or miss;
- the physical address;
- the uncacheable and system attributes of the entry;
- a fault code. The code reports a page fault on a miss, or a protection fault when a write hits a read-only page.

Top module: `vps_tlb`

## Requirements
- R1: After reset every way is free, `rsp_valid` is low, and any lookup misses.
- R2: An entry hits when `base <= vaddr < base + 2^size`. The physical address is `pbase + (vaddr & (2^size - 1))`. Fill sizes are clamped into the range 12..22, so a size of 0 acts as 12.
- R3: The set used by a lookup or a fill is `(addr >> 12) & (SETS - 1)`. For a fill, `addr` is the base after it is aligned to the entry's size. A fill never disturbs other sets.
- R4: A fill takes the lowest-numbered free way of its set. If no way is free, it replaces the least-recently-used way. The new entry always becomes most-recently-used.
- R5: A lookup with `lk_touch` high that hits makes the hit entry most-recently-used. With `lk_touch` low, the recency order is left unchanged.
- R6: A hit returns the entry's uncacheable and system flags. A miss returns both flags low.
- R7: A write (`lk_kind`=1) that hits a non-writable entry raises `rsp_prot_fault` with code 2. Reads and fetches of that page, and writes to writable pages, return code 0.
- R8: Fault codes are 0 for none, 1 for a read (`lk_kind`=0), 2 for a write (`lk_kind`=1), and 3 for any other kind (2 or 3). A miss returns the code for its kind with `rsp_paddr` equal to 0.
- R9: `inv_all` frees every way of every set.
- R10: A demap frees only the entry whose range covers `dm_vaddr`, and the address may be anywhere inside that page. A demap that matches nothing changes nothing.
- R11: When several operations arrive in one cycle, the flush wins over a demap, a demap wins over a fill, and any of the three suppresses a lookup's recency refresh. A lookup always sees the table as it stood before that edge.
- R12: `rsp_valid` is high exactly one cycle after each cycle in which `lk_valid` is high.
- R13: With `SETS`=1 the buffer is fully associative. All entries share set 0 and compete for its ways regardless of address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2/3 fetch |
| lk_touch | input | 1 | Refresh recency on hit |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical address (0 on miss) |
| rsp_uncached | output | 1 | Hit entry is uncacheable |
| rsp_system | output | 1 | Hit entry is a system page |
| rsp_prot_fault | output | 1 | Write to a read-only page |
| rsp_fault_code | output | 2 | 0 none, 1 load, 2 store, 3 instruction |
| ins_valid | input | 1 | Fill request |
| ins_vbase | input | 32 | Fill virtual base |
| ins_pbase | input | 32 | Fill physical base |
| ins_log2sz | input | 5 | Fill page size as log2 bytes |
| ins_writable | input | 1 | Fill entry writable |
| ins_uncached | input | 1 | Fill entry uncacheable |
| ins_system | input | 1 | Fill entry system page |
| inv_all | input | 1 | Flush every entry |
| dm_valid | input | 1 | Demap request |
| dm_vaddr | input | 32 | Address inside the page to demap |

## Verification
The lookup is tried with four kinds of address:
- the first and last byte of a page, and the byte one past its end, which separate a range compare from an exact tag match;
- addresses with the same set bits but different tags, which fill one set past its ways and expose the replacement order;
- repeated hits with and without recency refresh, which tell a refreshing lookup from a passive one;
- a large page, checked in a fully associative instance, which shows that the offset mask follows the size of the entry that hit.

Read, write and fetch kinds are each applied to both hits and misses, so that every fault code and the protection case are seen. Operations that share one cycle are issued together to check their priority.

// File: rtl/vps_tlb_pkg.sv
package vps_tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int BASE_SHIFT = 12;
    localparam int MAX_SHIFT  = 22;
    localparam int SZ_W       = $clog2(MAX_SHIFT + 1);

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LOAD  = 2'd1,
        FLT_STORE = 2'd2,
        FLT_INSTR = 2'd3
    } fault_e;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vbase;
        logic [PA_W-1:0] pbase;
        logic [SZ_W-1:0] lsz;
        logic            wr;
        logic            uc;
        logic            sys;
    } entry_t;

    function automatic logic [SZ_W-1:0] clamp_lsz(input logic [SZ_W-1:0] l);
        if (l < SZ_W'(BASE_SHIFT)) return SZ_W'(BASE_SHIFT);
        if (l > SZ_W'(MAX_SHIFT))  return SZ_W'(MAX_SHIFT);
        return l;
    endfunction

    function automatic logic [VA_W-1:0] page_mask(input logic [SZ_W-1:0] l);
        return (VA_W'(1) << l) - VA_W'(1);
    endfunction

    function automatic fault_e fault_for(input logic [1:0] kind);
        if (kind == KIND_READ)  return FLT_LOAD;
        if (kind == KIND_WRITE) return FLT_STORE;
        return FLT_INSTR;
    endfunction

endpackage

// File: rtl/vps_tlb_match.sv
module vps_tlb_match
    import vps_tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  entry_t [WAYS-1:0] ents,
    input  logic [VA_W-1:0]   va,
    output logic [WAYS-1:0]   hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [VA_W:0] lim;
        assign lim = {1'b0, ents[w].vbase} + ({1'b0, VA_W'(1)} << ents[w].lsz);
        assign hit_vec[w] = ents[w].valid
                          && (va >= ents[w].vbase)
                          && ({1'b0, va} < lim);
    end
endmodule

// File: rtl/vps_tlb_lru.sv
module vps_tlb_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] q_set,
    output logic [WAY_W-1:0] victim
);
    // rank 0 = most recent, WAYS-1 = least recent; ranks form a permutation
    logic [WAY_W-1:0] rank [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank[s][w] <= WAY_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank[touch_set][w] <= '0;
                else if (rank[touch_set][w] < rank[touch_set][touch_way])
                    rank[touch_set][w] <= rank[touch_set][w] + WAY_W'(1);
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++)
            if (rank[q_set][w] == WAY_W'(WAYS - 1))
                victim = WAY_W'(w);
    end
endmodule

// File: rtl/vps_tlb.sv
module vps_tlb
    import vps_tlb_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic [1:0]      lk_kind,
    input  logic            lk_touch,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_uncached,
    output logic            rsp_system,
    output logic            rsp_prot_fault,
    output logic [1:0]      rsp_fault_code,
    input  logic            ins_valid,
    input  logic [VA_W-1:0] ins_vbase,
    input  logic [PA_W-1:0] ins_pbase,
    input  logic [SZ_W-1:0] ins_log2sz,
    input  logic            ins_writable,
    input  logic            ins_uncached,
    input  logic            ins_system,
    input  logic            inv_all,
    input  logic            dm_valid,
    input  logic [VA_W-1:0] dm_vaddr
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    entry_t [WAYS-1:0] tbl [SETS];
    logic [SETS*WAYS-1:0] occ_flat;

    function automatic logic [SET_W-1:0] set_of(input logic [VA_W-1:0] a);
        return SET_W'((a >> BASE_SHIFT) & VA_W'(SETS - 1));
    endfunction

    function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r = '0;
        for (int i = WAYS - 1; i >= 0; i--)
            if (v[i]) r = WAY_W'(i);
        return r;
    endfunction

    always_comb begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                occ_flat[s*WAYS + w] = tbl[s][w].valid;
    end

    // ---- lookup path ----
    logic [SET_W-1:0] lk_set;
    logic [WAYS-1:0]  lk_vec;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    entry_t           lk_ent;

    assign lk_set = set_of(lk_vaddr);
    vps_tlb_match #(.WAYS(WAYS)) u_lk_match (
        .ents(tbl[lk_set]), .va(lk_vaddr), .hit_vec(lk_vec)
    );
    assign lk_hit = |lk_vec;
    assign lk_way = lowest(lk_vec);
    assign lk_ent = tbl[lk_set][lk_way];

    // ---- demap path ----
    logic [SET_W-1:0] dm_set;
    logic [WAYS-1:0]  dm_vec;
    assign dm_set = set_of(dm_vaddr);
    vps_tlb_match #(.WAYS(WAYS)) u_dm_match (
        .ents(tbl[dm_set]), .va(dm_vaddr), .hit_vec(dm_vec)
    );

    // ---- fill path ----
    logic [SZ_W-1:0]  ins_lsz;
    logic [VA_W-1:0]  ins_vb;
    logic [SET_W-1:0] ins_set;
    logic [WAYS-1:0]  ins_free;
    logic [WAY_W-1:0] lru_victim, ins_way;
    entry_t           ins_ent;

    assign ins_lsz = clamp_lsz(ins_log2sz);
    assign ins_vb  = ins_vbase & ~page_mask(ins_lsz);
    assign ins_set = set_of(ins_vb);
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            ins_free[w] = ~occ_flat[int'(ins_set)*WAYS + w];
    end
    assign ins_way = (|ins_free) ? lowest(ins_free) : lru_victim;
    assign ins_ent = '{valid: 1'b1, vbase: ins_vb,
                       pbase: ins_pbase & ~PA_W'(page_mask(ins_lsz)),
                       lsz: ins_lsz, wr: ins_writable,
                       uc: ins_uncached, sys: ins_system};

    // ---- operation priority: flush > demap > fill > recency refresh ----
    logic do_ins, do_touch, rc_touch;
    logic [SET_W-1:0] rc_set;
    logic [WAY_W-1:0] rc_way;

    assign do_ins   = ins_valid && !inv_all && !dm_valid;
    assign do_touch = lk_valid && lk_touch && lk_hit && !inv_all && !dm_valid && !ins_valid;
    assign rc_touch = do_ins || do_touch;
    assign rc_set   = do_ins ? ins_set : lk_set;
    assign rc_way   = do_ins ? ins_way : lk_way;

    vps_tlb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst(rst), .touch(rc_touch), .touch_set(rc_set),
        .touch_way(rc_way), .q_set(ins_set), .victim(lru_victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tbl[s] <= '0;
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tbl[s][w].valid <= 1'b0;
        end else if (dm_valid) begin
            if (|dm_vec) tbl[dm_set][lowest(dm_vec)].valid <= 1'b0;
        end else if (do_ins) begin
            tbl[ins_set][ins_way] <= ins_ent;
        end
    end

    // ---- registered response ----
    logic prot_now;
    assign prot_now = lk_hit && (lk_kind == KIND_WRITE) && !lk_ent.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_paddr      <= '0;
            rsp_uncached   <= 1'b0;
            rsp_system     <= 1'b0;
            rsp_prot_fault <= 1'b0;
            rsp_fault_code <= FLT_NONE;
        end else begin
            rsp_valid      <= lk_valid;
            rsp_hit        <= lk_valid && lk_hit;
            rsp_paddr      <= (lk_valid && lk_hit)
                              ? lk_ent.pbase + PA_W'(lk_vaddr & page_mask(lk_ent.lsz))
                              : '0;
            rsp_uncached   <= lk_valid && lk_hit && lk_ent.uc;
            rsp_system     <= lk_valid && lk_hit && lk_ent.sys;
            rsp_prot_fault <= lk_valid && prot_now;
            if (lk_valid && (!lk_hit || prot_now))
                rsp_fault_code <= fault_for(lk_kind);
            else
                rsp_fault_code <= FLT_NONE;
        end
    end
endmodule

// File: rtl/vps_tlb_checker.sv
module vps_tlb_checker #(
    parameter int SETS = 4,
    parameter int WAYS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lk_valid,
    input logic                 ins_valid,
    input logic                 inv_all,
    input logic                 dm_valid,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [31:0]          rsp_paddr,
    input logic                 rsp_uncached,
    input logic                 rsp_prot_fault,
    input logic [1:0]           rsp_fault_code,
    input logic [SETS*WAYS-1:0] occ_flat
);
    p_resp_follows_r12: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    p_resp_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    p_prot_store_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_prot_fault |-> (rsp_hit && rsp_fault_code == 2'd2));
    p_miss_code_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_fault_code != 2'd0 && rsp_paddr == '0 && !rsp_uncached));
    p_clean_hit_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && !rsp_prot_fault) |-> (rsp_fault_code == 2'd0));
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (occ_flat == '0));
    p_demap_shrinks_r10: assert property (@(posedge clk) disable iff (rst)
        (dm_valid && !inv_all) |=> ($countones(occ_flat) <= $past($countones(occ_flat))));
    p_fill_occupies_r4: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !inv_all && !dm_valid) |=> (occ_flat != '0));
endmodule

bind vps_tlb vps_tlb_checker #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .ins_valid(ins_valid),
    .inv_all(inv_all), .dm_valid(dm_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
    .rsp_prot_fault(rsp_prot_fault), .rsp_fault_code(rsp_fault_code),
    .occ_flat(occ_flat)
);

// File: tb/vps_tlb_bench.sv
module vps_tlb_bench;
    logic clk = 0;
    always #2 clk = ~clk;

    logic rst = 1;
    logic lk_valid = 0, lk_touch = 0;
    logic [31:0] lk_vaddr = 0;
    logic [1:0] lk_kind = 0;
    logic ins_valid = 0, ins_writable = 0, ins_uncached = 0, ins_system = 0;
    logic [31:0] ins_vbase = 0, ins_pbase = 0;
    logic [4:0] ins_log2sz = 0;
    logic inv_all = 0, dm_valid = 0;
    logic [31:0] dm_vaddr = 0;

    logic d_valid, d_hit, d_uc, d_sys, d_prot;
    logic [31:0] d_pa;
    logic [1:0] d_code;
    logic f_valid, f_hit, f_uc, f_sys, f_prot;
    logic [31:0] f_pa;
    logic [1:0] f_code;

    vps_tlb #(.SETS(4), .WAYS(4)) u_vps_tlb (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_touch(lk_touch), .rsp_valid(d_valid),
        .rsp_hit(d_hit), .rsp_paddr(d_pa), .rsp_uncached(d_uc),
        .rsp_system(d_sys), .rsp_prot_fault(d_prot), .rsp_fault_code(d_code),
        .ins_valid(ins_valid), .ins_vbase(ins_vbase), .ins_pbase(ins_pbase),
        .ins_log2sz(ins_log2sz), .ins_writable(ins_writable),
        .ins_uncached(ins_uncached), .ins_system(ins_system),
        .inv_all(inv_all), .dm_valid(dm_valid), .dm_vaddr(dm_vaddr));

    vps_tlb #(.SETS(1), .WAYS(4)) u_vps_tlb_fa (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_kind(lk_kind), .lk_touch(lk_touch), .rsp_valid(f_valid),
        .rsp_hit(f_hit), .rsp_paddr(f_pa), .rsp_uncached(f_uc),
        .rsp_system(f_sys), .rsp_prot_fault(f_prot), .rsp_fault_code(f_code),
        .ins_valid(ins_valid), .ins_vbase(ins_vbase), .ins_pbase(ins_pbase),
        .ins_log2sz(ins_log2sz), .ins_writable(ins_writable),
        .ins_uncached(ins_uncached), .ins_system(ins_system),
        .inv_all(inv_all), .dm_valid(dm_valid), .dm_vaddr(dm_vaddr));

    int total = 0, fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all operation tasks start and end at a falling edge
    task automatic ins(input logic [31:0] va, input logic [31:0] pa, input logic [4:0] lsz,
                       input logic wr, input logic uc, input logic sys);
        ins_valid = 1; ins_vbase = va; ins_pbase = pa; ins_log2sz = lsz;
        ins_writable = wr; ins_uncached = uc; ins_system = sys;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] kind, input logic touch);
        lk_valid = 1; lk_vaddr = va; lk_kind = kind; lk_touch = touch;
        @(negedge clk);
        lk_valid = 0; lk_touch = 0;
    endtask

    task automatic flush();
        inv_all = 1;
        @(negedge clk);
        inv_all = 0;
    endtask

    task automatic demap(input logic [31:0] va);
        dm_valid = 1; dm_vaddr = va;
        @(negedge clk);
        dm_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid idle", 32'(d_valid), 0);
        look(32'h0001_3000, 2'd0, 0);
        chk("R1 miss after reset", 32'(d_hit), 0);
        chk("R8 read miss code", 32'(d_code), 1);
    endtask

    task automatic t_basic();
        ins(32'h0001_3000, 32'h0008_0000, 5'd12, 1, 0, 1);
        look(32'h0001_3ABC, 2'd0, 0);
        chk("R12 valid after req", 32'(d_valid), 1);
        chk("R2 hit", 32'(d_hit), 1);
        chk("R2 paddr", d_pa, 32'h0008_0ABC);
        chk("R6 system", 32'(d_sys), 1);
        chk("R6 not uncached", 32'(d_uc), 0);
        @(negedge clk);
        chk("R12 valid drops", 32'(d_valid), 0);
        look(32'h0001_3FFF, 2'd0, 0);
        chk("R2 last byte paddr", d_pa, 32'h0008_0FFF);
        look(32'h0001_4000, 2'd0, 0);
        chk("R2 past end misses", 32'(d_hit), 0);
        ins(32'h0002_2000, 32'h0000_9000, 5'd12, 1, 1, 0);
        look(32'h0002_2010, 2'd0, 0);
        chk("R6 uncached", 32'(d_uc), 1);
        chk("R6 sys low", 32'(d_sys), 0);
        chk("R2 paddr uc", d_pa, 32'h0000_9010);
    endtask

    task automatic t_prot();
        ins(32'h0003_1000, 32'h0004_4000, 5'd12, 0, 0, 0);
        look(32'h0003_1008, 2'd1, 0);
        chk("R7 prot on write", 32'(d_prot), 1);
        chk("R7 store code", 32'(d_code), 2);
        chk("R7 still hit", 32'(d_hit), 1);
        look(32'h0003_1008, 2'd0, 0);
        chk("R7 read no fault", {d_prot, d_code}, 0);
        look(32'h0003_1008, 2'd2, 0);
        chk("R7 fetch no fault", {d_prot, d_code}, 0);
        look(32'h0001_3000, 2'd1, 0);
        chk("R7 writable no fault", {d_prot, d_code}, 0);
    endtask

    task automatic t_codes();
        look(32'h0777_7000, 2'd0, 0); chk("R8 read miss", 32'(d_code), 1);
        chk("R8 miss paddr 0", d_pa, 0);
        look(32'h0777_7000, 2'd1, 0); chk("R8 write miss", 32'(d_code), 2);
        look(32'h0777_7000, 2'd2, 0); chk("R8 fetch miss", 32'(d_code), 3);
        look(32'h0777_7000, 2'd3, 0); chk("R8 other miss", 32'(d_code), 3);
    endtask

    task automatic fill_set1();
        ins(32'h0000_1000, 32'h0010_1000, 5'd12, 1, 0, 0);
        ins(32'h0000_5000, 32'h0010_5000, 5'd12, 1, 0, 0);
        ins(32'h0000_9000, 32'h0010_9000, 5'd12, 1, 0, 0);
        ins(32'h0000_D000, 32'h0010_D000, 5'd12, 1, 0, 0);
    endtask

    task automatic t_lru();
        flush();
        ins(32'h0000_2000, 32'h0010_2000, 5'd12, 1, 0, 0);
        fill_set1();
        ins(32'h0001_1000, 32'h0011_1000, 5'd12, 1, 0, 0);
        look(32'h0000_1000, 2'd0, 0); chk("R4 oldest evicted", 32'(d_hit), 0);
        look(32'h0000_5000, 2'd0, 0); chk("R4 second kept", 32'(d_hit), 1);
        look(32'h0000_D000, 2'd0, 0); chk("R4 fourth kept", 32'(d_hit), 1);
        look(32'h0001_1004, 2'd0, 0); chk("R4 new entry paddr", d_pa, 32'h0011_1004);
        look(32'h0000_2000, 2'd0, 0); chk("R3 other set untouched", 32'(d_hit), 1);
    endtask

    task automatic t_touch();
        flush();
        fill_set1();
        look(32'h0000_1000, 2'd0, 1);
        ins(32'h0001_1000, 32'h0011_1000, 5'd12, 1, 0, 0);
        look(32'h0000_1000, 2'd0, 0); chk("R5 touched survives", 32'(d_hit), 1);
        look(32'h0000_5000, 2'd0, 0); chk("R5 next oldest evicted", 32'(d_hit), 0);
        flush();
        fill_set1();
        look(32'h0000_1000, 2'd0, 0);
        ins(32'h0001_1000, 32'h0011_1000, 5'd12, 1, 0, 0);
        look(32'h0000_1000, 2'd0, 0); chk("R5 passive lookup no refresh", 32'(d_hit), 0);
        look(32'h0000_5000, 2'd0, 0); chk("R5 passive keeps second", 32'(d_hit), 1);
    endtask

    task automatic t_flush();
        flush();
        look(32'h0000_5000, 2'd0, 0); chk("R9 flushed set1", 32'(d_hit), 0);
        look(32'h0001_3000, 2'd0, 0); chk("R9 flushed set3", 32'(d_hit), 0);
    endtask

    task automatic t_demap();
        ins(32'h0000_1000, 32'h0010_1000, 5'd12, 1, 0, 0);
        ins(32'h0000_5000, 32'h0010_5000, 5'd12, 1, 0, 0);
        demap(32'h0000_1ABC);
        look(32'h0000_1000, 2'd0, 0); chk("R10 demapped misses", 32'(d_hit), 0);
        look(32'h0000_5000, 2'd0, 0); chk("R10 neighbour kept", 32'(d_hit), 1);
        demap(32'h0777_7000);
        look(32'h0000_5000, 2'd0, 0); chk("R10 no-match demap harmless", 32'(d_hit), 1);
    endtask

    task automatic t_prio();
        flush();
        ins(32'h0000_1000, 32'h0010_1000, 5'd12, 1, 0, 0);
        inv_all = 1; ins_valid = 1; ins_vbase = 32'h0000_5000; ins_pbase = 32'h0010_5000;
        ins_log2sz = 5'd12; lk_valid = 1; lk_vaddr = 32'h0000_1000; lk_kind = 0;
        @(negedge clk);
        inv_all = 0; ins_valid = 0; lk_valid = 0;
        chk("R11 lookup sees old state", 32'(d_hit), 1);
        look(32'h0000_5000, 2'd0, 0); chk("R11 flush beats fill", 32'(d_hit), 0);
        look(32'h0000_1000, 2'd0, 0); chk("R11 flush applied", 32'(d_hit), 0);
        ins_valid = 1; ins_vbase = 32'h0000_9000; ins_pbase = 32'h0010_9000;
        lk_valid = 1; lk_vaddr = 32'h0000_9000;
        @(negedge clk);
        ins_valid = 0; lk_valid = 0;
        chk("R11 same-cycle lookup misses", 32'(d_hit), 0);
        look(32'h0000_9000, 2'd0, 0); chk("R11 fill then visible", 32'(d_hit), 1);
        dm_valid = 1; dm_vaddr = 32'h0000_9000;
        ins_valid = 1; ins_vbase = 32'h0000_D000; ins_pbase = 32'h0010_D000;
        @(negedge clk);
        dm_valid = 0; ins_valid = 0;
        look(32'h0000_D000, 2'd0, 0); chk("R11 demap beats fill", 32'(d_hit), 0);
        look(32'h0000_9000, 2'd0, 0); chk("R11 demap applied", 32'(d_hit), 0);
    endtask

    task automatic t_fa();
        flush();
        ins(32'h0040_0000, 32'h0120_0000, 5'd21, 1, 0, 0);
        look(32'h005F_FFFC, 2'd0, 0);
        chk("R13 large page hit", 32'(f_hit), 1);
        chk("R2 large page paddr", f_pa, 32'h013F_FFFC);
        look(32'h0060_0000, 2'd0, 0); chk("R2 large past end", 32'(f_hit), 0);
        look(32'h003F_FFFF, 2'd0, 0); chk("R2 large below base", 32'(f_hit), 0);
        look(32'h0040_0010, 2'd0, 0); chk("R3 large page in set 0", d_pa, 32'h0120_0010);
        flush();
        for (int i = 1; i <= 5; i++)
            ins(32'(i) << 12, 32'h0020_0000 + (32'(i) << 12), 5'd12, 1, 0, 0);
        look(32'h0000_1000, 2'd0, 0);
        chk("R13 one set evicts oldest", 32'(f_hit), 0);
        chk("R3 spread sets keep it", 32'(d_hit), 1);
        look(32'h0000_2000, 2'd0, 0); chk("R13 second kept", 32'(f_hit), 1);
        ins(32'h0000_7000, 32'h0000_A000, 5'd0, 1, 0, 0);
        look(32'h0000_7FFF, 2'd0, 0); chk("R2 size clamp paddr", f_pa, 32'h0000_AFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_prot();
        t_codes();
        t_lru();
        t_touch();
        t_flush();
        t_demap();
        t_prio();
        t_fa();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule